// File: doc/BRIEF.md
# Filtered Quadrature x4 Decoder

This block turns the two square-wave channels of an incremental shaft or linear encoder into direction-resolved count strobes. The channels arrive already converted to single-ended logic levels. Each one first crosses into the system clock domain through a two-stage synchronizer. It then passes a persistence filter, which accepts a new level only after that level has stayed put for a programmable number of clocks. This rejects the short spikes that electrical noise puts on long encoder cables.

The clean pair is decoded at full x4 resolution: every rising and falling edge of either channel is one count. Each count leaves the block as a single-clock pulse on either the up or the down output. A pair of legal-looking edges that land in the same clock cannot be ordered, so the block drops it and latches an error flag. An optional signed accumulator, selected by a parameter, adds the up pulses and subtracts the down pulses, giving an axis position that wraps in two's complement. A clear input zeroes it, for example when a homing mark is seen.

Top module: `qdec_x4`

## Requirements
- R1: A filtered channel takes a new level only when its synchronized input has differed from it on FILT_N consecutive clock edges (FILT_N ≥ 2, default 4). A raw excursion shorter than FILT_N clocks causes no pulse and no change of position.
- R2: Channel A leading channel B is the up direction. With the pair written {A,B}, each of the steps 00→10, 10→11, 11→01 and 01→00 produces exactly one up pulse.
- R3: The reverse steps 00→01, 01→11, 11→10 and 10→00, where B leads A, each produce exactly one down pulse.
- R4: One full encoder cycle, made of one rising and one falling edge on each channel, yields exactly four pulses in the same direction.
- R5: A pulse lasts exactly one clock, and up and down are never high in the same cycle.
- R6: If both filtered channels change on the same edge, no pulse is produced and seq_err goes high. seq_err then stays high until rst.
- R7: With the position counter present, position rises by one on each up pulse and falls by one on each down pulse. It wraps modulo 2^POS_W, so in a 4-bit counter one up step from 7 gives -8.
- R8: clr_pos sets position to zero on the next edge and wins over a pulse that lands in the same cycle.
- R9: While rst is high and after it falls, up_pulse, dn_pulse and seq_err are 0 and position is 0. The filtered state starts at {A,B}=00.
- R10: A raw input change that is held steady leads to its pulse on the (FILT_N+3)-th rising edge after the change: two edges in the synchronizer, FILT_N in the filter, and one in the pulse register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_pos | input | 1 | Clears the position counter |
| enc_a | input | 1 | Raw encoder channel A, asynchronous |
| enc_b | input | 1 | Raw encoder channel B, asynchronous |
| up_pulse | output | 1 | One-clock strobe per up count |
| dn_pulse | output | 1 | One-clock strobe per down count |
| seq_err | output | 1 | Sticky flag for a simultaneous change on both channels |
| position | output | POS_W | Signed accumulated count (zero if HAS_POS is 0) |

## Verification
Several assertions rely on FILT_N being at least 2. The single-clock pulse check and the filter check both assume that a filtered level cannot move on two consecutive edges, and this is true only when FILT_N ≥ 2. The bench therefore uses the default of 4. It changes one channel at a time, and it holds each level well past the filter window before the next change, so every legal step settles before the next one starts. The only exceptions are deliberate: a same-clock change of both inputs to provoke the sequence error, and pulses of FILT_N-1 and FILT_N clocks to probe the filter threshold. The counter is narrowed to 4 bits so that wraparound is reached in a few steps.

// File: rtl/qdec_pkg.sv
package qdec_pkg;

    typedef struct packed {
        logic a;
        logic b;
    } quad_t;

    typedef enum logic [1:0] {
        STEP_NONE = 2'd0,
        STEP_UP   = 2'd1,
        STEP_BAD  = 2'd2,
        STEP_DOWN = 2'd3
    } step_t;

    // Position of a {A,B} state around the cycle; the up direction counts upward
    function automatic logic [1:0] quad_phase(input quad_t q);
        return {q.b, q.a ^ q.b};
    endfunction

    // Phase difference decides the move: +1 up, -1 down, 2 both changed
    function automatic step_t classify(input quad_t prev, input quad_t cur);
        logic [1:0] d;
        d = quad_phase(cur) - quad_phase(prev);
        return step_t'(d);
    endfunction

endpackage

// File: rtl/qdec_sync.sv
module qdec_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) pipe[0] <= '0;
        else     pipe[0] <= din;
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) pipe[s] <= '0;
                else     pipe[s] <= pipe[s-1];
            end
        end
    endgenerate

    assign dout = pipe[STAGES-1];
endmodule

// File: rtl/qdec_filter.sv
module qdec_filter #(
    parameter int N = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    localparam int CW = (N > 1) ? $clog2(N) : 1;
    localparam logic [CW-1:0] LAST = CW'(N - 1);

    logic [CW-1:0] run_q;
    logic          lvl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
            lvl_q <= 1'b0;
        end else if (din != lvl_q) begin
            if (run_q == LAST) begin
                lvl_q <= din;
                run_q <= '0;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end else begin
            run_q <= '0;
        end
    end

    assign dout = lvl_q;

    // R1
    filt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(lvl_q) |-> ($past(din) == lvl_q));
endmodule

// File: rtl/qdec_step.sv
module qdec_step
    import qdec_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  quad_t cur,
    output logic  up,
    output logic  dn,
    output logic  err
);
    quad_t prev_q;
    step_t kind;
    logic  up_q, dn_q, err_q;

    assign kind = classify(prev_q, cur);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            up_q   <= 1'b0;
            dn_q   <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            prev_q <= cur;
            up_q   <= (kind == STEP_UP);
            dn_q   <= (kind == STEP_DOWN);
            err_q  <= err_q | (kind == STEP_BAD);
        end
    end

    assign up  = up_q;
    assign dn  = dn_q;
    assign err = err_q;

    // R5
    no_both_chk: assert property (@(posedge clk) disable iff (rst) !(up_q && dn_q));
    // R5
    up_single_chk: assert property (@(posedge clk) disable iff (rst) up_q |=> !up_q);
    // R5
    dn_single_chk: assert property (@(posedge clk) disable iff (rst) dn_q |=> !dn_q);
    // R6
    bad_no_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (cur.a != prev_q.a && cur.b != prev_q.b) |=> !(up_q || dn_q));
    // R6
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst) err_q |=> err_q);
endmodule

// File: rtl/qdec_x4.sv
module qdec_x4
    import qdec_pkg::*;
#(
    parameter int FILT_N  = 4,
    parameter int POS_W   = 16,
    parameter bit HAS_POS = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_pos,
    input  logic             enc_a,
    input  logic             enc_b,
    output logic             up_pulse,
    output logic             dn_pulse,
    output logic             seq_err,
    output logic [POS_W-1:0] position
);
    localparam int NCH = 2;

    logic [NCH-1:0] raw_v, sync_v, filt_v;
    quad_t          clean;

    assign raw_v = {enc_a, enc_b};

    qdec_sync #(.W(NCH), .STAGES(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .din (raw_v),
        .dout(sync_v)
    );

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_filt
            qdec_filter #(.N(FILT_N)) u_filt (
                .clk (clk),
                .rst (rst),
                .din (sync_v[c]),
                .dout(filt_v[c])
            );
        end
    endgenerate

    assign clean = quad_t'(filt_v);

    qdec_step u_step (
        .clk(clk),
        .rst(rst),
        .cur(clean),
        .up (up_pulse),
        .dn (dn_pulse),
        .err(seq_err)
    );

    generate
        if (HAS_POS) begin : g_pos
            logic [POS_W-1:0] pos_q;

            always_ff @(posedge clk) begin
                if (rst || clr_pos)  pos_q <= '0;
                else if (up_pulse)   pos_q <= pos_q + POS_W'(1);
                else if (dn_pulse)   pos_q <= pos_q - POS_W'(1);
            end

            assign position = pos_q;

            // R7
            pos_up_chk: assert property (@(posedge clk) disable iff (rst)
                (up_pulse && !clr_pos) |=> (pos_q == $past(pos_q) + POS_W'(1)));
            // R7
            pos_dn_chk: assert property (@(posedge clk) disable iff (rst)
                (dn_pulse && !clr_pos) |=> (pos_q == $past(pos_q) - POS_W'(1)));
            // R8
            pos_clr_chk: assert property (@(posedge clk) disable iff (rst)
                clr_pos |=> (pos_q == '0));
        end else begin : g_nopos
            assign position = '0;
        end
    endgenerate
endmodule

// File: tb/test_qdec_x4.sv
`timescale 1ns/1ps
module test_qdec_x4;
    localparam int N  = 4;
    localparam int PW = 4;

    logic clk = 1'b0;
    logic rst, clr_pos, enc_a, enc_b;
    logic up_pulse, dn_pulse, seq_err;
    logic [PW-1:0] position;

    int checks = 0;
    int fails  = 0;
    int up_tot = 0;
    int dn_tot = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    qdec_x4 #(.FILT_N(N), .POS_W(PW), .HAS_POS(1'b1)) i_qdec_x4 (
        .clk(clk), .rst(rst), .clr_pos(clr_pos), .enc_a(enc_a), .enc_b(enc_b),
        .up_pulse(up_pulse), .dn_pulse(dn_pulse), .seq_err(seq_err), .position(position)
    );

    always @(posedge clk) begin
        if (up_pulse) up_tot++;
        if (dn_pulse) dn_tot++;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_eq(input string tag, input int act, input int exp);
        chk(act == exp, tag, act, exp);
    endtask

    // Moves both inputs at a negedge, then lets the result settle
    task automatic move(input logic a, input logic b, input int settle);
        @(negedge clk);
        enc_a = a;
        enc_b = b;
        repeat (settle) @(negedge clk);
    endtask

    task automatic t_reset;
        rst = 1'b1; clr_pos = 1'b0; enc_a = 1'b0; enc_b = 1'b0;
        repeat (4) @(negedge clk);
        chk_eq("R9 up in reset", up_pulse, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk_eq("R9 up after reset", up_pulse, 0);
        chk_eq("R9 dn after reset", dn_pulse, 0);
        chk_eq("R9 err after reset", seq_err, 0);
        chk_eq("R9 position after reset", position, 0);
    endtask

    task automatic t_latency;
        int u0 = up_tot;
        @(negedge clk);
        enc_a = 1'b1;
        repeat (N + 2) @(posedge clk);
        @(negedge clk);
        chk_eq("R10 no pulse before edge N+3", up_pulse, 0);
        @(posedge clk);
        @(negedge clk);
        chk_eq("R10 up pulse at edge N+3", up_pulse, 1);
        chk_eq("R10 dn low with up", dn_pulse, 0);
        @(negedge clk);
        chk_eq("R5 up lasts one clock", up_pulse, 0);
        repeat (4) @(negedge clk);
        chk_eq("R2 00->10 one up", up_tot - u0, 1);
        chk_eq("R7 position after one up", position, 1);
    endtask

    task automatic t_forward;
        int u0 = up_tot, d0 = dn_tot;
        move(1, 1, 14);
        move(0, 1, 14);
        move(0, 0, 14);
        chk_eq("R2 three more up steps", up_tot - u0, 3);
        chk_eq("R2 no down on forward", dn_tot - d0, 0);
        chk_eq("R7 position 4", position, 4);
    endtask

    task automatic t_wrap;
        int u0 = up_tot;
        move(1, 0, 14);
        move(1, 1, 14);
        move(0, 1, 14);
        move(0, 0, 14);
        chk_eq("R4 one full cycle is four ups", up_tot - u0, 4);
        chk_eq("R7 wrap 7+1 to -8", position, 4'b1000);
    endtask

    task automatic t_reverse;
        int u0 = up_tot, d0 = dn_tot;
        move(0, 1, 14);
        move(1, 1, 14);
        move(1, 0, 14);
        move(0, 0, 14);
        chk_eq("R3 reverse cycle four downs", dn_tot - d0, 4);
        chk_eq("R3 no up on reverse", up_tot - u0, 0);
        chk_eq("R7 -8 minus 4 wraps to 4", position, 4);
    endtask

    task automatic t_glitch;
        int u0 = up_tot, d0 = dn_tot;
        @(negedge clk);
        enc_b = 1'b1;
        repeat (N - 1) @(negedge clk);
        enc_b = 1'b0;
        repeat (14) @(negedge clk);
        chk_eq("R1 short pulse no up", up_tot - u0, 0);
        chk_eq("R1 short pulse no down", dn_tot - d0, 0);
        chk_eq("R1 short pulse position", position, 4);
        @(negedge clk);
        enc_b = 1'b1;
        repeat (N) @(negedge clk);
        enc_b = 1'b0;
        repeat (14) @(negedge clk);
        chk_eq("R1 N-clock pulse gives one down", dn_tot - d0, 1);
        chk_eq("R1 N-clock pulse gives one up", up_tot - u0, 1);
        chk_eq("R1 position back to 4", position, 4);
    endtask

    task automatic t_clear;
        int u0 = up_tot;
        @(negedge clk);
        clr_pos = 1'b1;
        enc_a = 1'b1;
        repeat (14) @(negedge clk);
        clr_pos = 1'b0;
        chk_eq("R8 pulse during clear seen", up_tot - u0, 1);
        chk_eq("R8 clear wins over pulse", position, 0);
        move(0, 0, 14);
        chk_eq("R8 counting resumes after clear", position, 4'b1111);
    endtask

    task automatic t_illegal;
        int u0 = up_tot, d0 = dn_tot;
        move(1, 1, 14);
        chk_eq("R6 no up on double change", up_tot - u0, 0);
        chk_eq("R6 no down on double change", dn_tot - d0, 0);
        chk_eq("R6 err raised", seq_err, 1);
        move(0, 1, 14);
        chk_eq("R6 legal step after error still counts", up_tot - u0, 1);
        chk_eq("R6 err stays high", seq_err, 1);
        move(0, 0, 14);
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk_eq("R6 err cleared by reset", seq_err, 0);
        chk_eq("R9 position cleared by reset", position, 0);
    endtask

    initial begin
        t_reset;
        t_latency;
        t_forward;
        t_wrap;
        t_reverse;
        t_glitch;
        t_clear;
        t_illegal;
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule